// File: doc/BRIEF.md
# Decimal Mantissa Adder with Shared Carry Flag

This block performs arithmetic on twelve-digit packed decimal mantissas. Each digit is a four-bit nibble holding 0 to 9. Digit 1 is the most significant and sits in bits 47:44. Digit 12 is the least significant and sits in bits 3:0. The caller presents an operation code, two mantissas (X and Y) and a 16-bit word. It pulses `valid_i` for one cycle, and on the next clock edge the block registers the result and raises `res_valid_o`.

The block supports three operations:

- **Full addition:** adds X and Y.
- **Word addition:** adds the 16-bit word, read as four decimal digits, into the low four digits of Y. A carry out of digit 9 keeps rippling upward.
- **Ten's complement:** complements X.

For the two additions the result is the new Y. For the complement it is the new X.

A single decimal-carry flag is kept inside the block. It feeds the least significant digit as carry in, and it is reloaded from the carry out of digit 1 after each addition. Exponents and signs are not handled. Operands are assumed to hold valid decimal digits.

Top module: `bcd_mant_unit`

## Requirements
- R1: After reset, and after any later reset, `res_o` is zero, `dc_o` is 0 and `res_valid_o` is 0.
- R2: For op 2'b00 (full add), one cycle after `valid_i` the result `res_o` equals (X + Y + carry flag) modulo 10^12, with each digit in its nibble, and `res_valid_o` is 1 for that one cycle.
- R3: After a full or word addition, `dc_o` is 1 exactly when the decimal sum reached 10^12 (overflow past digit 1), and 0 otherwise.
- R4: The carry flag value held before an addition is added into digit 12 (bits 3:0) of that addition.
- R5: For op 2'b01 (word add), `res_o` equals (Y + W + carry flag) modulo 10^12, where W is `word_i` read as four decimal digits placed in digits 9..12. Carries from digit 9 ripple into digits 8..1.
- R6: Word addition updates `dc_o` by the same overflow rule as full addition.
- R7: For op 2'b10 (ten's complement), `res_o` equals (10^12 - X) modulo 10^12, so an all-zero X gives zero. The flag is cleared whatever its prior value, and it is not used as carry in.
- R8: Op 2'b11 is reserved. It leaves `res_o` and `dc_o` unchanged and does not raise `res_valid_o`.
- R9: In a cycle without `valid_i`, `res_valid_o` is 0 on the next cycle, and `res_o` and `dc_o` hold their values.
- R10: Whenever `res_valid_o` is 1, every nibble of `res_o` is in the range 0..9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Start one operation this cycle |
| op_i | input | 2 | 00 full add, 01 word add, 10 ten's complement, 11 reserved |
| mant_x_i | input | 48 | Mantissa X, digit 1 in bits 47:44 |
| mant_y_i | input | 48 | Mantissa Y, digit 1 in bits 47:44 |
| word_i | input | 16 | Four decimal digits added into digits 9..12 |
| res_o | output | 48 | Registered result mantissa |
| res_valid_o | output | 1 | One-cycle pulse marking a new result |
| dc_o | output | 1 | Decimal-carry flag |

## Verification
The bench targets the following corner cases:

- **Carry chains across all twelve digits.** Examples are 999999999999 plus a carry-in of one, and 500000000000 plus itself. A design that applied the +6 correction without propagating the digit carry would leave a 9 or an A nibble in the result.
- **Carry in from the flag.** The same operands are added once with the flag clear and once with it set. A design that ignored the flag, or fed it at the wrong end of the mantissa, gives a result off by one or by 10^11.
- **Word addition rippling past digit 9.** 9999 plus one in the low digits tests this. A design that limited the add to four digits would drop the carry.
- **Complement of zero and of one.** These must give zero and twelve nines with the flag cleared. A design that left the carry out in the flag would report 1 after complementing zero.
- **The reserved code.** It must leave a set flag and the prior result intact.

// File: rtl/bcd_mant_pkg.sv
package bcd_mant_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_WORD = 2'b01,
    OP_CPL  = 2'b10,
    OP_RSV  = 2'b11
  } bcd_op_e;

  localparam int unsigned DIGIT_W = 4;
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import bcd_mant_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_i,
  input  logic [DIGIT_W-1:0] b_i,
  input  logic               c_i,
  output logic [DIGIT_W-1:0] s_o,
  output logic               c_o
);
  logic [DIGIT_W:0] raw;
  logic [DIGIT_W:0] fixed;

  always_comb begin
    raw   = {1'b0, a_i} + {1'b0, b_i} + {{DIGIT_W{1'b0}}, c_i};
    fixed = raw + 5'd6;
    if (raw > 5'd9) begin
      s_o = fixed[DIGIT_W-1:0];
      c_o = 1'b1;
    end else begin
      s_o = raw[DIGIT_W-1:0];
      c_o = 1'b0;
    end
  end
endmodule

// File: rtl/bcd_ripple_add.sv
module bcd_ripple_add
  import bcd_mant_pkg::*;
#(
  parameter int unsigned DIGITS = 12,
  localparam int unsigned W     = DIGITS * DIGIT_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [DIGITS:0] carry;
  assign carry[0] = c_i;

  // index 0 is the least significant digit
  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    bcd_digit_add u_dig (
      .a_i (a_i[d*DIGIT_W +: DIGIT_W]),
      .b_i (b_i[d*DIGIT_W +: DIGIT_W]),
      .c_i (carry[d]),
      .s_o (s_o[d*DIGIT_W +: DIGIT_W]),
      .c_o (carry[d+1])
    );
  end

  assign c_o = carry[DIGITS];
endmodule

// File: rtl/bcd_nines.sv
module bcd_nines
  import bcd_mant_pkg::*;
#(
  parameter int unsigned DIGITS = 12,
  localparam int unsigned W     = DIGITS * DIGIT_W
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);
  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    assign y_o[d*DIGIT_W +: DIGIT_W] = 4'd9 - x_i[d*DIGIT_W +: DIGIT_W];
  end
endmodule

// File: rtl/bcd_mant_unit.sv
module bcd_mant_unit
  import bcd_mant_pkg::*;
#(
  parameter int unsigned DIGITS      = 12,
  parameter int unsigned WORD_DIGITS = 4,
  localparam int unsigned W          = DIGITS * DIGIT_W,
  localparam int unsigned WW         = WORD_DIGITS * DIGIT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [1:0]    op_i,
  input  logic [W-1:0]  mant_x_i,
  input  logic [W-1:0]  mant_y_i,
  input  logic [WW-1:0] word_i,
  output logic [W-1:0]  res_o,
  output logic          res_valid_o,
  output logic          dc_o
);
  bcd_op_e      op;
  logic [W-1:0] x_nines;
  logic [W-1:0] add_a, add_b, add_s;
  logic         add_ci, add_co;
  logic [W-1:0] res_q;
  logic         dc_q, vld_q;

  assign op = bcd_op_e'(op_i);

  bcd_nines #(.DIGITS(DIGITS)) u_nines (
    .x_i (mant_x_i),
    .y_o (x_nines)
  );

  // one shared adder: operands steered per operation
  always_comb begin
    add_a  = mant_x_i;
    add_b  = mant_y_i;
    add_ci = dc_q;
    unique case (op)
      OP_WORD: add_a = {{(W-WW){1'b0}}, word_i};
      OP_CPL: begin
        add_a  = x_nines;
        add_b  = '0;
        add_ci = 1'b1;
      end
      default: ;
    endcase
  end

  bcd_ripple_add #(.DIGITS(DIGITS)) u_add (
    .a_i (add_a),
    .b_i (add_b),
    .c_i (add_ci),
    .s_o (add_s),
    .c_o (add_co)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      dc_q  <= 1'b0;
      vld_q <= 1'b0;
    end else if (valid_i && op != OP_RSV) begin
      res_q <= add_s;
      dc_q  <= (op == OP_CPL) ? 1'b0 : add_co;
      vld_q <= 1'b1;
    end else begin
      vld_q <= 1'b0;
    end
  end

  assign res_o       = res_q;
  assign res_valid_o = vld_q;
  assign dc_o        = dc_q;
endmodule

// File: rtl/bcd_mant_unit_chk.sv
module bcd_mant_unit_chk
  import bcd_mant_pkg::*;
#(
  parameter int unsigned DIGITS = 12,
  localparam int unsigned W     = DIGITS * DIGIT_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [1:0]   op_i,
  input logic [W-1:0] mant_x_i,
  input logic [W-1:0] mant_y_i,
  input logic [W-1:0] res_o,
  input logic         res_valid_o,
  input logic         dc_o
);
  logic [DIGITS-1:0] bad_dig;
  for (genvar d = 0; d < DIGITS; d++) begin : g_bad
    assign bad_dig[d] = res_o[d*DIGIT_W +: DIGIT_W] > 4'd9;
  end

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i != OP_RSV |=> res_valid_o);

  assert_zero_add_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_ADD && mant_x_i == '0 && !dc_o
    |=> res_o == $past(mant_y_i) && !dc_o);

  assert_cpl_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CPL |=> !dc_o);

  assert_rsv_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_RSV |=> !res_valid_o && $stable(dc_o) && $stable(res_o));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !res_valid_o && $stable(dc_o) && $stable(res_o));

  assert_digits_ok_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> bad_dig == '0);
endmodule

bind bcd_mant_unit bcd_mant_unit_chk #(.DIGITS(DIGITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .op_i        (op_i),
  .mant_x_i    (mant_x_i),
  .mant_y_i    (mant_y_i),
  .res_o       (res_o),
  .res_valid_o (res_valid_o),
  .dc_o        (dc_o)
);

// File: tb/bcd_mant_unit_tb.sv
module bcd_mant_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [47:0] mant_x_i = '0;
  logic [47:0] mant_y_i = '0;
  logic [15:0] word_i = '0;
  logic [47:0] res_o;
  logic        res_valid_o;
  logic        dc_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  bcd_mant_unit u_dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .mant_x_i, .mant_y_i, .word_i,
    .res_o, .res_valid_o, .dc_o
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        cin;
    logic [47:0] x;
    logic [47:0] y;
    logic [15:0] w;
    logic [47:0] res;
    logic        dc;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 48'h000000000123, 48'h000000000456, 16'h0, 48'h000000000579, 1'b0, "R2 "},
    '{2'b00, 1'b1, 48'h000000000123, 48'h000000000456, 16'h0, 48'h000000000580, 1'b0, "R4 "},
    '{2'b00, 1'b0, 48'h500000000000, 48'h500000000000, 16'h0, 48'h000000000000, 1'b1, "R3 "},
    '{2'b00, 1'b1, 48'h999999999999, 48'h000000000000, 16'h0, 48'h000000000000, 1'b1, "R4 "},
    '{2'b00, 1'b0, 48'h123456789012, 48'h876543210987, 16'h0, 48'h999999999999, 1'b0, "R3 "},
    '{2'b00, 1'b0, 48'h000000000045, 48'h000000000055, 16'h0, 48'h000000000100, 1'b0, "R2 "},
    '{2'b01, 1'b0, 48'h0,            48'h000000009999, 16'h0001, 48'h000000010000, 1'b0, "R5 "},
    '{2'b01, 1'b1, 48'h0,            48'h999999999999, 16'h0000, 48'h000000000000, 1'b1, "R6 "},
    '{2'b01, 1'b0, 48'h0,            48'h123400005678, 16'h4321, 48'h123400009999, 1'b0, "R5 "},
    '{2'b10, 1'b1, 48'h000000000001, 48'h0,            16'h0, 48'h999999999999, 1'b0, "R7 "},
    '{2'b10, 1'b0, 48'h000000000000, 48'h0,            16'h0, 48'h000000000000, 1'b0, "R7 "},
    '{2'b10, 1'b1, 48'h123456789012, 48'h0,            16'h0, 48'h876543210988, 1'b0, "R7 "}
  };

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one op: drive after a falling edge, sample at the falling edge after capture
  task automatic run_op(input logic [1:0] op, input logic [47:0] x, input logic [47:0] y,
                        input logic [15:0] w);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; mant_x_i = x; mant_y_i = y; word_i = w;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic set_flag(input logic v);
    run_op(2'b10, 48'h0, 48'h0, 16'h0);
    if (v) run_op(2'b00, 48'h999999999999, 48'h999999999999, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 res", res_o, 48'h0);
    chk("R1 dc", {47'h0, dc_o}, 48'h0);
    chk("R1 valid", {47'h0, res_valid_o}, 48'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      set_flag(VECS[i].cin);
      run_op(VECS[i].op, VECS[i].x, VECS[i].y, VECS[i].w);
      chk({VECS[i].tag, " res"}, res_o, VECS[i].res);
      chk({VECS[i].tag, " dc"}, {47'h0, dc_o}, {47'h0, VECS[i].dc});
      chk("R2 valid pulse", {47'h0, res_valid_o}, 48'h1);
    end

    // R9: idle cycle drops the pulse and holds state
    @(negedge clk_i);
    chk("R9 valid low", {47'h0, res_valid_o}, 48'h0);
    chk("R9 res held", res_o, 48'h876543210988);

    // R8: reserved op with flag set
    set_flag(1'b1);
    chk("R3 flag set", {47'h0, dc_o}, 48'h1);
    run_op(2'b11, 48'h111111111111, 48'h222222222222, 16'h0);
    chk("R8 valid", {47'h0, res_valid_o}, 48'h0);
    chk("R8 dc", {47'h0, dc_o}, 48'h1);
    chk("R8 res", res_o, 48'h999999999998);
    // R8: flag still feeds the next add
    run_op(2'b00, 48'h0, 48'h000000000010, 16'h0);
    chk("R8 R4 carry kept", res_o, 48'h000000000011);

    // R1: reset mid-run
    set_flag(1'b1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 rerst res", res_o, 48'h0);
    chk("R1 rerst dc", {47'h0, dc_o}, 48'h0);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule